// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block takes a 32-bit SDRAM array from power-up to normal service and then keeps it refreshed. It sits idle until a start pulse arrives. It then waits out a power-up delay and issues the initial command sequence: precharge of all banks, a mode register write, eight auto-refresh commands, and a second mode register write. Some device families want the mode written before the refreshes and some want it after, so the block does both. It then performs ten read-then-write-back accesses to the lowest words so the devices settle, and raises a ready flag.

Once the second mode write has gone out, a two-stage refresh timer runs. It is a prescaler followed by a period counter, and each expiry adds four refreshes to a pending count. Those refreshes are issued only while an external grant says the bus is free. Refreshes that cannot go out at once are held in the count, so none are dropped. The sizing logic outside the block selects the column multiplexing directly while it probes. When it reports the capacity measured in both column modes, the block keeps 9-column mode only if that mode found more memory. If the larger capacity is 32 MB or less, the block also halves the refresh rate by switching the prescaler.

Commands appear on a 3-bit code with an address bus alongside. The address is a byte address on a 32-bit bus, so device address pin k sits on bus bit k+2.

Top module: `sdram_bringup_seq`

## Requirements
- R1: After reset `cmd` is 0 (no operation) and `ready` is low, and no command is issued until `startPulse` is seen. Command codes: 0 none, 1 precharge-all, 2 auto-refresh, 3 mode register set, 4 read, 5 write.
- R2: The first command, a precharge-all, appears exactly POWERUP_CYCLES cycles after the clock edge that samples `startPulse`. A start pulse received at any time other than idle after reset is ignored.
- R3: The initial order is: precharge-all, mode register set, INIT_REFS (8) auto-refresh, mode register set, then DUMMY_COUNT (10) read/write pairs. Refreshes driven by the timer may only come between the dummy accesses.
- R4: Mode register set drives `addr` = 0x0088, which is 0x22 shifted left by 2. Precharge-all drives `addr` = 0x1000, which is device pin 10. Dummy pair i (i = 0..9) reads and then writes byte address 4*i.
- R5: Two successive commands are at least CMD_GAP+1 cycles apart.
- R6: The refresh timer stays stopped until the second mode register set. After that, each expiry, every PERIOD_COUNT*prescale cycles, adds REF_PER_EXPIRY (4) refreshes.
- R7: A timer refresh is issued only in a cycle following one in which `refGrant` was high. Refreshes held back while the grant is low are kept in a count and issued later, so the long-run refresh count is unchanged.
- R8: `ready` rises in the same cycle as the tenth dummy write and stays high afterwards.
- R9: Until the first `sizeValid`, `colNine` follows `colSelIn`. From then on `colNine` is 1 exactly when `size9Log2` > `size8Log2` in the latest report, and `colSelIn` is ignored.
- R10: On each `sizeValid`, if max(`size8Log2`, `size9Log2`) is at most SMALL_LOG2 (25, meaning 32 MB), the prescaler becomes PRESCALE_SLOW and the refresh rate halves. Otherwise it is PRESCALE_FAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins the bring-up sequence |
| colSelIn | input | 1 | Column mode chosen by the sizing logic before it reports |
| sizeValid | input | 1 | Strobe: capacity report present |
| size8Log2 | input | SIZE_W | log2 of bytes found in 8-column mode |
| size9Log2 | input | SIZE_W | log2 of bytes found in 9-column mode |
| refGrant | input | 1 | Bus free for a refresh |
| cmd | output | 3 | Command code, one cycle per command |
| addr | output | ADDR_W | Address bus for the command |
| colNine | output | 1 | 1 selects 9-column multiplexing |
| ready | output | 1 | Bring-up complete |

## Verification
A wrong sequencer state shows up at once on the command code. A missing, extra or reordered strobe changes the logged command list within the few hundred cycles of bring-up. The delay and spacing counters are checked to the exact cycle against the start edge. Faults in the timer, the prescaler choice or the pending count show no single symptom. They do show as a refresh total outside its tolerance over a window of several timer periods, or as a refresh issued in a cycle the grant was low. A wrong column decision is visible on `colNine` one cycle after the size report.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_REF = 3'd2,
    CMD_MRS = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5
  } cmd_e;

  typedef struct packed {
    logic startWait;
    logic issuePre;
    logic issueMrs;
    logic issueRef;
    logic issueRd;
    logic issueWr;
    logic refreshEnable;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int INIT_REFS   = 8,
  parameter int DUMMY_COUNT = 10,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             waitDone,
  input  logic             gapFree,
  input  logic             pendingNz,
  input  logic             refGrant,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] wordIdx,
  output logic             ready
);

  localparam int REF_W = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_MRS1, ST_REF, ST_MRS2, ST_DUMMY, ST_READY
  } state_e;

  state_e           state, stateNext;
  logic [REF_W-1:0] refCnt, refCntNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             wrPhase, wrPhaseNext;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    refCntNext  = refCnt;
    idxNext     = idx;
    wrPhaseNext = wrPhase;
    case (state)
      ST_IDLE: if (startPulse) begin
        strobe.startWait = 1'b1;
        stateNext        = ST_WAIT;
      end
      ST_WAIT: if (waitDone && gapFree) begin
        strobe.issuePre = 1'b1;
        stateNext       = ST_MRS1;
      end
      ST_MRS1: if (gapFree) begin
        strobe.issueMrs = 1'b1;
        refCntNext      = '0;
        stateNext       = ST_REF;
      end
      ST_REF: if (gapFree) begin
        strobe.issueRef = 1'b1;
        if (refCnt == REF_W'(INIT_REFS - 1)) stateNext = ST_MRS2;
        else refCntNext = refCnt + REF_W'(1);
      end
      ST_MRS2: if (gapFree) begin
        strobe.issueMrs      = 1'b1;
        strobe.refreshEnable = 1'b1;
        idxNext              = '0;
        wrPhaseNext          = 1'b0;
        stateNext            = ST_DUMMY;
      end
      ST_DUMMY: if (gapFree) begin
        if (pendingNz && refGrant) begin
          strobe.issueRef = 1'b1;
        end else if (!wrPhase) begin
          strobe.issueRd = 1'b1;
          wrPhaseNext    = 1'b1;
        end else begin
          strobe.issueWr = 1'b1;
          wrPhaseNext    = 1'b0;
          if (idx == IDX_W'(DUMMY_COUNT - 1)) stateNext = ST_READY;
          else idxNext = idx + IDX_W'(1);
        end
      end
      ST_READY: if (gapFree && pendingNz && refGrant) strobe.issueRef = 1'b1;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      refCnt  <= '0;
      idx     <= '0;
      wrPhase <= 1'b0;
    end else begin
      state   <= stateNext;
      refCnt  <= refCntNext;
      idx     <= idxNext;
      wrPhase <= wrPhaseNext;
    end
  end

  assign wordIdx = idx;
  assign ready   = (state == ST_READY);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issuePre, strobe.issueMrs, strobe.issueRef, strobe.issueRd, strobe.issueWr}));

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issuePre || strobe.issueMrs || strobe.issueRef || strobe.issueRd || strobe.issueWr) |-> gapFree);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int POWERUP_CYCLES = 10000,
  parameter int CMD_GAP        = 1,
  parameter int PERIOD_COUNT   = 195,
  parameter int PRESCALE_FAST  = 8,
  parameter int PRESCALE_SLOW  = 16,
  parameter int REF_PER_EXPIRY = 4,
  parameter int PEND_W         = 4,
  parameter int SIZE_W         = 6,
  parameter int SMALL_LOG2     = 25,
  parameter int MODE_VALUE     = 'h22,
  parameter int ADDR_SHIFT     = 2,
  parameter int IDX_W          = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              refGrant,
  input  logic              colSelIn,
  input  logic              sizeValid,
  input  logic [SIZE_W-1:0] size8Log2,
  input  logic [SIZE_W-1:0] size9Log2,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              colNine,
  output logic              waitDone,
  output logic              gapFree,
  output logic              pendingNz
);

  localparam int WAIT_W = $clog2(POWERUP_CYCLES + 1);
  localparam int GAP_W  = (CMD_GAP > 0) ? $clog2(CMD_GAP + 1) : 1;
  localparam int PRE_W  = $clog2(PRESCALE_SLOW);
  localparam int PER_W  = $clog2(PERIOD_COUNT);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << (10 + ADDR_SHIFT);
  localparam logic [ADDR_W-1:0] MRS_ADDR = ADDR_W'(MODE_VALUE) << ADDR_SHIFT;

  logic [WAIT_W-1:0] waitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [PRE_W-1:0]  preCnt, presLimit;
  logic [PER_W-1:0]  perCnt;
  logic [PEND_W-1:0] pending;
  logic [PEND_W:0]   pendSum;
  logic              refreshOn, tick, expiry, refDec, anyIssue;
  logic              sizeKnown, colLatched, slowRate;
  logic [SIZE_W-1:0] sizeMax;
  cmd_e              cmdReg;

  assign anyIssue = strobe.issuePre | strobe.issueMrs | strobe.issueRef |
                    strobe.issueRd | strobe.issueWr;

  // power-up delay
  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.startWait) waitCnt <= WAIT_W'(POWERUP_CYCLES - 1);
    else if (waitCnt != '0) waitCnt <= waitCnt - WAIT_W'(1);
  end
  assign waitDone = (waitCnt == '0);

  // command spacing
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= '0;
    else if (anyIssue) gapCnt <= GAP_W'(CMD_GAP);
    else if (gapCnt != '0) gapCnt <= gapCnt - GAP_W'(1);
  end
  assign gapFree = (gapCnt == '0);

  // refresh timer: prescaler then period counter
  assign presLimit = slowRate ? PRE_W'(PRESCALE_SLOW - 1) : PRE_W'(PRESCALE_FAST - 1);
  assign tick      = refreshOn && (preCnt >= presLimit);
  assign expiry    = tick && (perCnt == PER_W'(PERIOD_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshOn <= 1'b0;
      preCnt    <= '0;
      perCnt    <= '0;
    end else begin
      if (strobe.refreshEnable) refreshOn <= 1'b1;
      if (!refreshOn || tick) preCnt <= '0;
      else preCnt <= preCnt + PRE_W'(1);
      if (expiry) perCnt <= '0;
      else if (tick) perCnt <= perCnt + PER_W'(1);
    end
  end

  // pending refresh count, saturating
  assign refDec  = strobe.issueRef && (pending != '0);
  assign pendSum = {1'b0, pending}
                 + (expiry ? (PEND_W + 1)'(REF_PER_EXPIRY) : '0)
                 - {{PEND_W{1'b0}}, refDec};

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else if (pendSum > {1'b0, PEND_MAX}) pending <= PEND_MAX;
    else pending <= pendSum[PEND_W-1:0];
  end
  assign pendingNz = (pending != '0);

  // sizing outcome
  assign sizeMax = (size9Log2 > size8Log2) ? size9Log2 : size8Log2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeKnown  <= 1'b0;
      colLatched <= 1'b0;
      slowRate   <= 1'b0;
    end else if (sizeValid) begin
      sizeKnown  <= 1'b1;
      colLatched <= (size9Log2 > size8Log2);
      slowRate   <= (sizeMax <= SIZE_W'(SMALL_LOG2));
    end
  end
  assign colNine = sizeKnown ? colLatched : colSelIn;

  // command and address register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= CMD_NOP;
      addr   <= '0;
    end else begin
      cmdReg <= CMD_NOP;
      addr   <= '0;
      if (strobe.issuePre) begin
        cmdReg <= CMD_PRE;
        addr   <= PRE_ADDR;
      end else if (strobe.issueMrs) begin
        cmdReg <= CMD_MRS;
        addr   <= MRS_ADDR;
      end else if (strobe.issueRef) begin
        cmdReg <= CMD_REF;
      end else if (strobe.issueRd) begin
        cmdReg <= CMD_RD;
        addr   <= ADDR_W'(wordIdx) << ADDR_SHIFT;
      end else if (strobe.issueWr) begin
        cmdReg <= CMD_WR;
        addr   <= ADDR_W'(wordIdx) << ADDR_SHIFT;
      end
    end
  end
  assign cmd = cmdReg;

  // R5
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (CMD_GAP > 0 && cmdReg != CMD_NOP) |=> (cmdReg == CMD_NOP));

  // R6
  early_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refreshOn |-> (pending == '0));

  // R7
  grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueRef && refreshOn) |-> refGrant);

  // R7
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending == PEND_MAX) |=> (pending >= PEND_MAX - PEND_W'(1)));

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int SIZE_W         = 6,
  parameter int POWERUP_CYCLES = 10000,
  parameter int CMD_GAP        = 1,
  parameter int PERIOD_COUNT   = 195,
  parameter int PRESCALE_FAST  = 8,
  parameter int PRESCALE_SLOW  = 16,
  parameter int REF_PER_EXPIRY = 4,
  parameter int PEND_W         = 4,
  parameter int SMALL_LOG2     = 25,
  parameter int INIT_REFS      = 8,
  parameter int DUMMY_COUNT    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              colSelIn,
  input  logic              sizeValid,
  input  logic [SIZE_W-1:0] size8Log2,
  input  logic [SIZE_W-1:0] size9Log2,
  input  logic              refGrant,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              colNine,
  output logic              ready
);

  localparam int IDX_W = (DUMMY_COUNT > 1) ? $clog2(DUMMY_COUNT) : 1;

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             waitDone, gapFree, pendingNz;

  sdram_seq_ctrl #(
    .INIT_REFS(INIT_REFS), .DUMMY_COUNT(DUMMY_COUNT), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .waitDone(waitDone),
    .gapFree(gapFree), .pendingNz(pendingNz), .refGrant(refGrant),
    .strobe(strobe), .wordIdx(wordIdx), .ready(ready)
  );

  sdram_seq_dp #(
    .ADDR_W(ADDR_W), .POWERUP_CYCLES(POWERUP_CYCLES), .CMD_GAP(CMD_GAP),
    .PERIOD_COUNT(PERIOD_COUNT), .PRESCALE_FAST(PRESCALE_FAST),
    .PRESCALE_SLOW(PRESCALE_SLOW), .REF_PER_EXPIRY(REF_PER_EXPIRY),
    .PEND_W(PEND_W), .SIZE_W(SIZE_W), .SMALL_LOG2(SMALL_LOG2),
    .MODE_VALUE('h22), .ADDR_SHIFT(2), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .refGrant(refGrant), .colSelIn(colSelIn), .sizeValid(sizeValid),
    .size8Log2(size8Log2), .size9Log2(size9Log2), .cmd(cmd), .addr(addr),
    .colNine(colNine), .waitDone(waitDone), .gapFree(gapFree),
    .pendingNz(pendingNz)
  );

endmodule

// File: tb/tb_sdram_bringup_seq.sv
module tb_sdram_bringup_seq;

  localparam int PU   = 20;
  localparam int GAP  = 1;
  localparam int PER  = 6;
  localparam int FAST = 4;
  localparam int SLOW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        colSelIn = 1'b0;
  logic        sizeValid = 1'b0;
  logic [5:0]  size8Log2 = '0;
  logic [5:0]  size9Log2 = '0;
  logic        refGrant = 1'b1;
  logic [2:0]  cmd;
  logic [15:0] addr;
  logic        colNine;
  logic        ready;

  sdram_bringup_seq #(
    .POWERUP_CYCLES(PU), .CMD_GAP(GAP), .PERIOD_COUNT(PER),
    .PRESCALE_FAST(FAST), .PRESCALE_SLOW(SLOW)
  ) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .colSelIn(colSelIn),
    .sizeValid(sizeValid), .size8Log2(size8Log2), .size9Log2(size9Log2),
    .refGrant(refGrant), .cmd(cmd), .addr(addr), .colNine(colNine),
    .ready(ready)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int logN = 0;
  int refTotal = 0;
  int preTotal = 0;
  int noGrantRef = 0;
  int minGap = 1000;
  int lastCyc = 0;
  logic grantAtEdge = 1'b1;
  logic readyPrev = 1'b0;
  logic readyAtLast = 1'b0;
  logic readyBeforeLast = 1'b1;
  logic [2:0]  cmdLog [64];
  logic [15:0] addrLog [64];
  int          cycLog [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    grantAtEdge <= refGrant;
  end

  always @(negedge clk) begin
    if (cmd != 3'd0) begin
      if (logN < 64) begin
        cmdLog[logN]  = cmd;
        addrLog[logN] = addr;
        cycLog[logN]  = cyc;
      end
      if (logN > 0 && (cyc - lastCyc) < minGap) minGap = cyc - lastCyc;
      lastCyc = cyc;
      logN++;
      if (cmd == 3'd2) refTotal++;
      if (cmd == 3'd1) preTotal++;
      if (cmd == 3'd2 && !grantAtEdge) noGrantRef++;
      if (cmd == 3'd5 && addr == 16'd36) begin
        readyAtLast     = ready;
        readyBeforeLast = readyPrev;
      end
    end
    readyPrev = ready;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // {size8, size9, expCol9, expSlow}
  localparam logic [13:0] VEC [7] = '{
    {6'd22, 6'd23, 1'b1, 1'b1},
    {6'd23, 6'd22, 1'b0, 1'b1},
    {6'd24, 6'd24, 1'b0, 1'b1},
    {6'd26, 6'd27, 1'b1, 1'b0},
    {6'd25, 6'd25, 1'b0, 1'b1},
    {6'd25, 6'd26, 1'b1, 1'b0},
    {6'd26, 6'd25, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int startCyc;
    int r0;
    int k;
    int d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd after reset", int'(cmd), 0);
    check("R1 ready after reset", int'(ready), 0);
    repeat (10) @(negedge clk);
    check("R1 no command before start", logN, 0);

    // R9 column select follows input before sizing
    colSelIn = 1'b1; #1;
    check("R9 colNine follows colSelIn=1", int'(colNine), 1);
    @(negedge clk); colSelIn = 1'b0; #1;
    check("R9 colNine follows colSelIn=0", int'(colNine), 0);

    // start, then a second pulse during the wait that must be ignored
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0; startCyc = cyc;
    repeat (5) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    k = 0;
    while (!ready && k < 2000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);

    // R2 delay to first command
    check("R2 first command is precharge", int'(cmdLog[0]), 1);
    check("R2 power-up delay cycles", cycLog[0] - startCyc, PU);
    // R4 addresses and R3 order
    check("R4 precharge addr", int'(addrLog[0]), 'h1000);
    check("R3 second command mode set", int'(cmdLog[1]), 3);
    check("R4 mode set addr", int'(addrLog[1]), 'h88);
    for (int i = 2; i < 10; i++) check("R3 init refresh", int'(cmdLog[i]), 2);
    check("R3 mode set after refreshes", int'(cmdLog[10]), 3);
    check("R4 second mode set addr", int'(addrLog[10]), 'h88);
    d = 0;
    for (int i = 11; i < 64 && d < 20; i++) begin
      if (cmdLog[i] != 3'd2) begin
        check("R3 dummy access kind", int'(cmdLog[i]), (d % 2 == 0) ? 4 : 5);
        check("R4 dummy access addr", int'(addrLog[i]), (d / 2) * 4);
        d++;
      end
    end
    check("R3 dummy access count", d, 20);
    // R8
    check("R8 ready with last write", int'(readyAtLast), 1);
    check("R8 ready low before last write", int'(readyBeforeLast), 0);
    // R5
    checkRange("R5 minimum spacing", minGap, GAP + 1, 1000);

    // R2 start after ready is ignored
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (60) @(negedge clk);
    check("R2 restart ignored", preTotal, 1);

    // R9 / R10 / R6 table of size reports
    for (int v = 0; v < 7; v++) begin
      size8Log2 = VEC[v][13:8];
      size9Log2 = VEC[v][7:2];
      colSelIn  = ~VEC[v][1];
      sizeValid = 1'b1;
      @(negedge clk); sizeValid = 1'b0;
      check("R9 column decision", int'(colNine), int'(VEC[v][1]));
      repeat (24) @(negedge clk);
      r0 = refTotal;
      repeat (240) @(negedge clk);
      if (VEC[v][0]) checkRange("R10 slow refresh count", refTotal - r0, 17, 23);
      else checkRange("R6 fast refresh count", refTotal - r0, 37, 43);
    end

    // R7 grant low holds refreshes, none are lost
    r0 = refTotal;
    refGrant = 1'b0;
    repeat (60) @(negedge clk);
    check("R7 no refresh while grant low", refTotal - r0, 0);
    refGrant = 1'b1;
    repeat (180) @(negedge clk);
    checkRange("R7 refreshes recovered", refTotal - r0, 37, 43);
    check("R7 refresh only after grant", noGrantRef, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule